// File: doc/BRIEF.md
# Multi-Class Service Rate Allocator

This block sets the service rate of each priority-class queue on one outgoing link and recomputes every rate once per update period. On an accepted period tick it samples every queue occupancy. It then computes a new rate for each class in turn, highest priority first, taking one clock per class.

Each new rate comes from a proportional correction of the class's previous rate. The correction scales with the distance between the occupancy and the target occupancy, and the scale is a power-of-two right shift. No correction is made while the occupancy is already moving toward its target. The result is then clamped. The floor is the class's guaranteed minimum. The ceiling is the link capacity left after the lower classes' minimums and the freshly computed rates of the higher classes are set aside.

Newly computed rates are held in shadow registers. They move to the outputs together at the next accepted tick. A one-cycle done pulse marks the end of the walk. Rates and occupancies are unsigned fixed point with `FRAC` fractional bits. Capacity, minimums and targets are configuration and must stay stable while the block runs. Class 0 has the highest priority.

The tick is a plain control pin with no back-pressure. A tick that arrives while the walk is in progress is dropped, so the tick spacing must exceed `NCLS` + 1 clocks.

Top module: `svc_rate_alloc`

## Requirements
- R1: While reset is held, every output rate equals its class minimum and every stored previous occupancy is zero.
- R2: Rates computed from the samples of one accepted tick appear on `rate_o` together, one clock after the next accepted tick. At all other times `rate_o` holds. The first accepted tick after reset therefore leaves the minimums on the outputs.
- R3: `done_o` is high for exactly one clock, `NCLS` clocks after the clock edge that accepted the tick.
- R4: A class keeps its previous rate (clamp still applied) when either of two conditions holds: target ≥ occupancy and the occupancy rose above the previous sample, or target ≤ occupancy and the occupancy fell below the previous sample.
- R5: Otherwise the unclamped new rate is u ± ((u·|x − xd|) >> (FRAC + shift)). The sign is + when x ≥ xd and − when x < xd, and the shifted magnitude is rounded toward zero.
- R6: The clamped rate is never below the class minimum. When the ceiling is below the minimum, the minimum wins.
- R7: The ceiling of class k is the capacity, minus the minimums of classes k+1 and up, minus the new rates just computed for classes 0 to k−1.
- R8: A tick that arrives during the walk is ignored. It takes no sample, commits nothing and leaves `rate_o` unchanged.
- R9: When the minimums sum to no more than the capacity, the output rates also sum to no more than the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Update-period boundary strobe |
| cap_i | input | DW | Link capacity per period (fixed point) |
| minr_i | input | NCLS*DW | Per-class minimum rate, class k at bits [k*DW +: DW] |
| tgt_i | input | NCLS*DW | Per-class target occupancy |
| shift_i | input | NCLS*SW | Per-class gain shift |
| occ_i | input | NCLS*DW | Per-class queue occupancy |
| rate_o | output | NCLS*DW | Committed per-class service rate |
| done_o | output | 1 | One-clock pulse at the end of the walk |

## Verification
The bench uses the default build: three classes, 16-bit values with 8 fractional bits and 5-bit shifts. It applies a capacity of 60 cells, a minimum of 5 cells per class, and targets of 100, 150 and 200 cells. At realistic shifts the corrections are a fraction of a cell, which exercises rounding toward zero. A shift of zero drives class 0 into its ceiling, squeezes class 1 down to its minimum, and pushes every class through the floor. Random occupancies up to 250 cells with shifts from 0 to 12 cover both hold conditions and the mixed clamp cases.

// File: rtl/sra_pkg.sv
package sra_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sra_walk.sv
module sra_walk #(
  parameter int NCLS = 3,
  localparam int IW = sra_pkg::idx_width(NCLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  output logic          start_o,
  output logic          commit_o,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(NCLS - 1);

  logic          busy_q, pend_q, done_q;
  logic [IW-1:0] idx_q;

  assign start_o  = tick_i && !busy_q;
  assign commit_o = start_o && pend_q;
  assign busy_o   = busy_q;
  assign idx_o    = idx_q;
  assign done_o   = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        pend_q <= 1'b0;
      end else if (busy_q) begin
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          pend_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(busy_q) && $past(idx_q) == LAST));
endmodule

// File: rtl/sra_step.sv
module sra_step #(
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int SW   = 5,
  parameter int CW   = 19
) (
  input  logic [DW-1:0]        u_prev,
  input  logic [DW-1:0]        x_now,
  input  logic [DW-1:0]        x_prev,
  input  logic [DW-1:0]        x_tgt,
  input  logic [DW-1:0]        r_min,
  input  logic signed [CW-1:0] ceil_i,
  input  logic [SW-1:0]        shift_i,
  output logic [DW-1:0]        u_new
);
  localparam int PW = 2 * DW + 1;
  localparam int EW = PW + 2;

  logic                 hold, below;
  logic [DW-1:0]        dmag;
  logic [PW-1:0]        pmag, smag;
  logic signed [EW-1:0] uext, mext, cext, stepv, cand, hi, lo;

  always_comb begin
    hold  = ((x_tgt >= x_now) && (x_now > x_prev)) ||
            ((x_tgt <= x_now) && (x_now < x_prev));
    below = x_now < x_tgt;
    dmag  = below ? (x_tgt - x_now) : (x_now - x_tgt);
    pmag  = PW'(u_prev) * PW'(dmag);
    smag  = pmag >> (FRAC + int'(shift_i));
    uext  = $signed(EW'(u_prev));
    mext  = $signed(EW'(r_min));
    cext  = EW'(ceil_i);
    stepv = $signed(EW'(smag));
    if (hold)       cand = uext;
    else if (below) cand = uext - stepv;
    else            cand = uext + stepv;
    hi    = (cand > cext) ? cext : cand;
    lo    = (hi < mext) ? mext : hi;
    u_new = lo[DW-1:0];
  end
endmodule

// File: rtl/svc_rate_alloc.sv
module svc_rate_alloc #(
  parameter int NCLS = 3,
  parameter int DW   = 16,
  parameter int FRAC = 8,
  parameter int SW   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [DW-1:0]      cap_i,
  input  logic [NCLS*DW-1:0] minr_i,
  input  logic [NCLS*DW-1:0] tgt_i,
  input  logic [NCLS*SW-1:0] shift_i,
  input  logic [NCLS*DW-1:0] occ_i,
  output logic [NCLS*DW-1:0] rate_o,
  output logic               done_o
);
  localparam int IW = sra_pkg::idx_width(NCLS);
  localparam int CW = DW + $clog2(NCLS + 1) + 1;

  logic [DW-1:0] occ_a [NCLS];
  logic [DW-1:0] min_a [NCLS];
  logic [DW-1:0] tgt_a [NCLS];
  logic [SW-1:0] sh_a  [NCLS];
  logic [DW-1:0] occ_s [NCLS];
  logic [DW-1:0] prv_q [NCLS];
  logic [DW-1:0] shd_q [NCLS];
  logic [DW-1:0] rate_q[NCLS];

  logic start, commit, busy, done;
  logic [IW-1:0] idx;
  logic [CW-1:0] used_q, lowsum;
  logic signed [CW-1:0] ceil_v;
  logic [DW-1:0] s_u, s_x, s_xp, s_xd, s_min, u_new;
  logic [SW-1:0] s_sh;

  for (genvar k = 0; k < NCLS; k++) begin : g_unpack
    assign occ_a[k] = occ_i[k*DW +: DW];
    assign min_a[k] = minr_i[k*DW +: DW];
    assign tgt_a[k] = tgt_i[k*DW +: DW];
    assign sh_a[k]  = shift_i[k*SW +: SW];
    assign rate_o[k*DW +: DW] = rate_q[k];
  end

  sra_walk #(.NCLS(NCLS)) u_walk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .start_o(start),
    .commit_o(commit), .busy_o(busy), .idx_o(idx), .done_o(done)
  );
  assign done_o = done;

  always_comb begin
    s_u = '0; s_x = '0; s_xp = '0; s_xd = '0; s_min = '0; s_sh = '0;
    lowsum = '0;
    for (int k = 0; k < NCLS; k++) begin
      if (IW'(k) == idx) begin
        s_u   = shd_q[k];
        s_x   = occ_s[k];
        s_xp  = prv_q[k];
        s_xd  = tgt_a[k];
        s_min = min_a[k];
        s_sh  = sh_a[k];
      end
      if (k > int'(idx)) lowsum = lowsum + CW'(min_a[k]);
    end
    ceil_v = $signed(CW'(cap_i)) - $signed(lowsum) - $signed(used_q);
  end

  sra_step #(.DW(DW), .FRAC(FRAC), .SW(SW), .CW(CW)) u_step (
    .u_prev(s_u), .x_now(s_x), .x_prev(s_xp), .x_tgt(s_xd), .r_min(s_min),
    .ceil_i(ceil_v), .shift_i(s_sh), .u_new(u_new)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int k = 0; k < NCLS; k++) begin
        occ_s[k]  <= '0;
        prv_q[k]  <= '0;
        shd_q[k]  <= min_a[k];
        rate_q[k] <= min_a[k];
      end
    end else begin
      if (start) begin
        used_q <= '0;
        for (int k = 0; k < NCLS; k++) occ_s[k] <= occ_a[k];
      end
      if (commit) begin
        for (int k = 0; k < NCLS; k++) rate_q[k] <= shd_q[k];
      end
      if (busy) begin
        used_q <= used_q + CW'(u_new);
        for (int k = 0; k < NCLS; k++) begin
          if (IW'(k) == idx) begin
            shd_q[k] <= u_new;
            prv_q[k] <= occ_s[k];
          end
        end
      end
    end
  end

  logic [CW-1:0] rsum, msum;
  always_comb begin
    rsum = '0;
    msum = '0;
    for (int k = 0; k < NCLS; k++) begin
      rsum = rsum + CW'(rate_q[k]);
      msum = msum + CW'(min_a[k]);
    end
  end

  // R9
  cap_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msum <= CW'(cap_i)) |-> (rsum <= CW'(cap_i)));
  // R2
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick_i) |-> $stable(rate_o));
  // R8
  busy_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick_i) |=> $stable(rate_o));

  for (genvar k = 0; k < NCLS; k++) begin : g_floor
    // R6
    rate_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_q[k] >= min_a[k]);
  end
endmodule

// File: tb/svc_rate_alloc_bench.sv
module svc_rate_alloc_bench;
  localparam int NCLS = 3;
  localparam int DW = 16;
  localparam int FRAC = 8;
  localparam int SW = 5;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [DW-1:0] cap;
  logic [NCLS*DW-1:0] minr, tgt, occ, rate;
  logic [NCLS*SW-1:0] shv;
  logic done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  svc_rate_alloc #(.NCLS(NCLS), .DW(DW), .FRAC(FRAC), .SW(SW)) u_svc_rate_alloc (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cap_i(cap), .minr_i(minr),
    .tgt_i(tgt), .shift_i(shv), .occ_i(occ), .rate_o(rate), .done_o(done)
  );

  int checks = 0;
  int errors = 0;
  longint m_rate[NCLS], m_shd[NCLS], m_prv[NCLS], m_min[NCLS], m_tgt[NCLS];
  int m_sh[NCLS];
  bit m_pend = 0;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint mstep(longint u, longint x, longint xp, longint xd,
                                   longint d, longint ceil, int l);
    longint c = u;
    bit hold = (xd >= x && x > xp) || (xd <= x && x < xp);
    if (!hold) begin
      longint mag = (x >= xd) ? x - xd : xd - x;
      longint p = (u * mag) >> (FRAC + l);
      c = (x >= xd) ? u + p : u - p;
    end
    if (c > ceil) c = ceil;
    if (c < d) c = d;
    return c;
  endfunction

  task automatic set_shifts(int a, int b, int c);
    m_sh[0] = a; m_sh[1] = b; m_sh[2] = c;
    for (int k = 0; k < NCLS; k++) shv[k*SW +: SW] = SW'(m_sh[k]);
  endtask

  task automatic period(longint o0, longint o1, longint o2, string tag, bit junk);
    longint ov[NCLS];
    longint used = 0;
    int cnt = 0;
    int pos = -1;
    longint rsum = 0;
    ov[0] = o0; ov[1] = o1; ov[2] = o2;
    @(negedge clk);
    for (int k = 0; k < NCLS; k++) occ[k*DW +: DW] = DW'(ov[k]);
    tick = 1'b1;
    if (m_pend) for (int k = 0; k < NCLS; k++) m_rate[k] = m_shd[k];
    m_pend = 1;
    for (int k = 0; k < NCLS; k++) begin
      longint low = 0;
      for (int j = k + 1; j < NCLS; j++) low += m_min[j];
      m_shd[k] = mstep(m_shd[k], ov[k], m_prv[k], m_tgt[k], m_min[k],
                       longint'(cap) - low - used, m_sh[k]);
      m_prv[k] = ov[k];
      used += m_shd[k];
    end
    @(negedge clk);
    tick = 1'b0;
    for (int k = 0; k < NCLS; k++) begin
      check(tag, rate[k*DW +: DW], m_rate[k]);
      rsum += rate[k*DW +: DW];
    end
    check("R9 budget", (rsum <= cap) ? 1 : 0, 1);
    if (junk) begin
      tick = 1'b1;
      for (int k = 0; k < NCLS; k++) occ[k*DW +: DW] = DW'(64000 - 1000 * k);
    end
    for (int c = 1; c <= NCLS + 1; c++) begin
      @(negedge clk);
      if (c == 1 && junk) begin
        tick = 1'b0;
        for (int k = 0; k < NCLS; k++) check("R8 busy tick", rate[k*DW +: DW], m_rate[k]);
      end
      if (done) begin
        cnt++;
        pos = c;
      end
    end
    check("R3 done count", cnt, 1);
    check("R3 done cycle", pos, NCLS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    cap = DW'(60 * 256);
    for (int k = 0; k < NCLS; k++) begin
      m_min[k] = 5 * 256;
      m_tgt[k] = (100 + 50 * k) * 256;
      m_prv[k] = 0;
      m_shd[k] = m_min[k];
      m_rate[k] = m_min[k];
      minr[k*DW +: DW] = DW'(m_min[k]);
      tgt[k*DW +: DW] = DW'(m_tgt[k]);
    end
    occ = '0;
    set_shifts(11, 12, 12);
    repeat (4) @(negedge clk);
    for (int k = 0; k < NCLS; k++) check("R1 reset rate", rate[k*DW +: DW], m_min[k]);
    rst_n = 1'b1;
    // R1 R2: first tick commits nothing; class 1 and 2 rise from cleared prev at/below target
    period(150 * 256, 150 * 256, 150 * 256, "R1 R2 first tick", 0);
    // R4 R5: commit of small fractional step for class 0, holds for class 1 and 2
    period(160 * 256, 140 * 256, 210 * 256 + 77, "R4 R5 step", 0);
    set_shifts(0, 0, 0);
    period(200 * 256, 200 * 256, 200 * 256, "R5 step", 0);
    // R7: shift 0 drives class 0 to its ceiling, squeezing lower classes
    period(0, 0, 0, "R7 ceiling", 0);
    // R6: far below target drives rates to the floor
    period(0, 0, 0, "R6 floor", 0);
    period(250 * 256, 250 * 256, 250 * 256, "R6 floor repeat", 0);
    // R4: above target and falling holds
    period(220 * 256, 220 * 256, 220 * 256, "R4 rise commit", 0);
    period(120 * 256, 170 * 256, 230 * 256, "R4 fall hold", 0);
    // R8: tick during walk is dropped
    period(90 * 256, 160 * 256, 190 * 256, "R8 pre", 1);
    period(90 * 256, 160 * 256, 190 * 256, "R8 commit", 0);
    for (int n = 0; n < 200; n++) begin
      set_shifts($urandom_range(0, 12), $urandom_range(0, 12), $urandom_range(0, 12));
      period($urandom_range(0, 64000), $urandom_range(0, 64000),
             $urandom_range(0, 64000), "R2 R5 R7 random", (n % 17) == 5);
    end
    period(100 * 256, 150 * 256, 200 * 256, "R2 final", 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule